// File: doc/BRIEF.md
# Conditional Trap Comparison Unit

This block decides whether a conditional trap instruction should fire. It takes two register operands and a 5-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. A width-select input chooses between word (32-bit) and doubleword (64-bit) comparison.

When a valid strobe accompanies the operands and at least one enabled relation holds, the block raises a program-exception request on the next clock cycle. The request carries a fixed subtype code that marks it as a trap. The surrounding pipeline consumes that request and does its own exception vectoring.

Top module: `trap_cond_unit`

## Requirements
- R1: After reset, and until the first strobed evaluation, `trap_req` is 0 and `trap_kind` is 0.
- R2: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B as signed two's-complement numbers.
- R3: Mask bit 3 (value 0x08) enables a trap when operand A is greater than operand B as signed numbers.
- R4: Mask bit 2 (value 0x04) enables a trap when the compared operand bits are equal. At most one of the three outcomes signed-less, signed-greater and equal can hold for one operand pair.
- R5: Mask bit 1 (value 0x02) enables a trap on unsigned A less than B. Mask bit 0 (value 0x01) enables a trap on unsigned A greater than B.
- R6: With `dword_mode` = 0, only bits 31:0 of each operand are compared, and bit 31 is the sign bit. Bits 63:32 have no effect on the result.
- R7: With `dword_mode` = 1, all 64 bits are compared, and bit 63 is the sign bit.
- R8: A trap is requested when any relation whose mask bit is set holds. While `trap_req` is 1, `trap_kind` equals 4'h3, the trap subtype of a program exception. While `trap_req` is 0, `trap_kind` is 0.
- R9: The result appears on the outputs in the cycle after the clock edge that samples `in_valid` = 1. After an edge that samples `in_valid` = 0, `trap_req` is 0.
- R10: A strobed evaluation with a mask of zero never raises a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: operands and mask are valid this cycle |
| op_a | input | 64 | First operand (A) |
| op_b | input | 64 | Second operand (B) |
| cond_mask | input | 5 | Relation enables: bit4 signed-lt, bit3 signed-gt, bit2 eq, bit1 unsigned-lt, bit0 unsigned-gt |
| dword_mode | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| trap_req | output | 1 | Registered program-exception request |
| trap_kind | output | 4 | Exception subtype: 4'h3 for a trap, 0 when idle |

## Verification
Single-bit masks are applied to operand pairs that straddle the sign boundary. For example, a negative A against a positive B makes signed-less true and unsigned-less false, so these pairs show that the signed and unsigned relations are kept apart. Pairs whose low words match but whose upper halves differ are run in both widths. They show that word mode ignores bits 63:32 and that doubleword mode does not. Further checks cover a zero mask, a missing strobe and the signed minimum and maximum values. A reference-model sweep over random operands, masks and widths then compares every relation combination.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN      = 64;
    localparam int MASK_W    = 5;
    localparam int KIND_W    = 4;
    localparam logic [KIND_W-1:0] KIND_NONE = 4'h0;
    localparam logic [KIND_W-1:0] KIND_TRAP = 4'h3;

    // Field order matches mask bit order (bit4 .. bit0)
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_flags_t;

    typedef struct packed {
        logic              req;
        logic [KIND_W-1:0] kind;
    } trap_state_t;
endpackage

// File: rtl/trap_rel_cmp.sv
module trap_rel_cmp
    import trap_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output rel_flags_t   flags
);
    always_comb begin
        flags.slt = $signed(a) < $signed(b);
        flags.sgt = $signed(a) > $signed(b);
        flags.eq  = a == b;
        flags.ult = a < b;
        flags.ugt = a > b;
    end

    always_comb begin
        // R4
        rel_excl_chk: assert ($countones({flags.slt, flags.sgt, flags.eq}) <= 1);
        // R5
        uns_excl_chk: assert (!(flags.ult && flags.ugt));
    end
endmodule

// File: rtl/trap_hit_reduce.sv
module trap_hit_reduce #(
    parameter int N = 5
) (
    input  logic [N-1:0] mask,
    input  logic [N-1:0] flags,
    output logic         hit
);
    logic [N-1:0] sel;

    for (genvar i = 0; i < N; i++) begin : g_sel
        assign sel[i] = mask[i] & flags[i];
    end

    assign hit = |sel;
endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
    import trap_pkg::*;
#(
    parameter int OP_W = XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [MASK_W-1:0] cond_mask,
    input  logic              dword_mode,
    output logic              trap_req,
    output logic [KIND_W-1:0] trap_kind
);
    localparam int HALF_W = OP_W / 2;
    localparam int NUM_W  = 2;

    rel_flags_t flags_w [NUM_W];
    rel_flags_t flags_sel;
    logic       hit;

    for (genvar g = 0; g < NUM_W; g++) begin : g_cmp
        localparam int CW = (g == 0) ? HALF_W : OP_W;
        trap_rel_cmp #(.W(CW)) u_cmp (
            .a     (op_a[CW-1:0]),
            .b     (op_b[CW-1:0]),
            .flags (flags_w[g])
        );
    end

    assign flags_sel = dword_mode ? flags_w[1] : flags_w[0];

    trap_hit_reduce #(.N(MASK_W)) u_reduce (
        .mask  (cond_mask),
        .flags (flags_sel),
        .hit   (hit)
    );

    trap_state_t state_d, state_q;

    always_comb begin
        state_d      = '0;
        state_d.req  = in_valid && hit;
        state_d.kind = (in_valid && hit) ? KIND_TRAP : KIND_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign trap_req  = state_q.req;
    assign trap_kind = state_q.kind;

    // R10
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '0) |=> !trap_req);
    // R9
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !trap_req);
    // R8
    kind_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_kind == KIND_TRAP);
    // R8
    kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_kind == KIND_NONE);
    // R6
    word_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dword_mode && cond_mask[2] &&
         op_a[HALF_W-1:0] == op_b[HALF_W-1:0]) |=> trap_req);
endmodule

// File: tb/tb_trap_cond_unit.sv
module tb_trap_cond_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [4:0]  cond_mask = '0;
    logic        dword_mode = 1'b0;
    logic        trap_req;
    logic [3:0]  trap_kind;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    trap_cond_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .cond_mask(cond_mask), .dword_mode(dword_mode),
        .trap_req(trap_req), .trap_kind(trap_kind)
    );

    function automatic logic ref_hit(input logic [63:0] a, input logic [63:0] b,
                                     input logic [4:0] m, input logic dw);
        logic slt, sgt, eq, ult, ugt;
        if (dw) begin
            slt = $signed(a) < $signed(b);
            sgt = $signed(a) > $signed(b);
            eq  = a == b;
            ult = a < b;
            ugt = a > b;
        end else begin
            slt = $signed(a[31:0]) < $signed(b[31:0]);
            sgt = $signed(a[31:0]) > $signed(b[31:0]);
            eq  = a[31:0] == b[31:0];
            ult = a[31:0] < b[31:0];
            ugt = a[31:0] > b[31:0];
        end
        return (m[4] & slt) | (m[3] & sgt) | (m[2] & eq) | (m[1] & ult) | (m[0] & ugt);
    endfunction

    task automatic check(input string req, input logic exp_req);
        logic [3:0] exp_kind;
        exp_kind = exp_req ? 4'h3 : 4'h0;
        n_chk++;
        if (trap_req !== exp_req || trap_kind !== exp_kind) begin
            n_bad++;
            $display("FAIL %s: req=%0b kind=%h expected req=%0b kind=%h",
                     req, trap_req, trap_kind, exp_req, exp_kind);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic eval(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic [4:0] m, input logic dw, input logic exp_req);
        @(negedge clk);
        op_a = a; op_b = b; cond_mask = m; dword_mode = dw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, exp_req);
    endtask

    task automatic t_reset;
        check("R1", 1'b0);
        @(negedge clk);
        check("R1", 1'b0);
    endtask

    task automatic t_signed;
        // R2: -1 < 1 signed, but not unsigned
        eval("R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, 1'b1, 1'b1);
        eval("R2", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h10, 1'b1, 1'b0);
        eval("R2", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 5'h10, 1'b1, 1'b1);
        // R3
        eval("R3", 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 5'h08, 1'b1, 1'b1);
        eval("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h08, 1'b1, 1'b0);
    endtask

    task automatic t_equal;
        eval("R4", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1'b1, 1'b1);
        eval("R4", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 5'h04, 1'b1, 1'b0);
        eval("R4", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 5'h18, 1'b1, 1'b0);
    endtask

    task automatic t_unsigned;
        eval("R5", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1, 1'b1);
        eval("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h02, 1'b1, 1'b0);
        eval("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, 1'b1, 1'b1);
        eval("R5", 64'd5, 64'd5, 5'h03, 1'b1, 1'b0);
    endtask

    task automatic t_word;
        // R6: upper halves differ, low words equal
        eval("R6", 64'hAAAA_AAAA_0000_0042, 64'h5555_5555_0000_0042, 5'h04, 1'b0, 1'b1);
        eval("R6", 64'hAAAA_AAAA_0000_0042, 64'h5555_5555_0000_0042, 5'h1B, 1'b0, 1'b0);
        // bit 31 is sign in word mode
        eval("R6", 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 5'h10, 1'b0, 1'b1);
        eval("R6", 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 5'h01, 1'b0, 1'b1);
    endtask

    task automatic t_dword;
        eval("R7", 64'hAAAA_AAAA_0000_0042, 64'h5555_5555_0000_0042, 5'h04, 1'b1, 1'b0);
        eval("R7", 64'hAAAA_AAAA_0000_0042, 64'h5555_5555_0000_0042, 5'h10, 1'b1, 1'b1);
        eval("R7", 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 5'h08, 1'b1, 1'b1);
    endtask

    task automatic t_any;
        eval("R8", 64'd3, 64'd9, 5'h1F, 1'b1, 1'b1);
        eval("R8", 64'd3, 64'd9, 5'h09, 1'b1, 1'b0);
    endtask

    task automatic t_strobe;
        // R9: result drops after an idle edge
        eval("R9", 64'd7, 64'd7, 5'h04, 1'b1, 1'b1);
        @(negedge clk);
        check("R9", 1'b0);
        // operands that would trap but no strobe
        op_a = 64'd1; op_b = 64'd1; cond_mask = 5'h1F;
        @(negedge clk);
        check("R9", 1'b0);
    endtask

    task automatic t_zero_mask;
        eval("R10", 64'd7, 64'd7, 5'h00, 1'b1, 1'b0);
        eval("R10", 64'h8000_0000_0000_0000, 64'd0, 5'h00, 1'b0, 1'b0);
    endtask

    task automatic t_random;
        logic [63:0] corners [6];
        corners[0] = 64'h8000_0000_0000_0000;
        corners[1] = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[2] = 64'h0000_0000_8000_0000;
        corners[3] = 64'h0000_0000_7FFF_FFFF;
        corners[4] = 64'h0;
        corners[5] = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            logic [4:0]  m;
            logic        dw;
            a  = {$urandom, $urandom};
            b  = (i % 4 == 0) ? a : {$urandom, $urandom};
            if (i % 5 == 1) a = corners[$urandom % 6];
            if (i % 7 == 2) b = corners[$urandom % 6];
            m  = 5'($urandom);
            dw = 1'($urandom);
            eval("R8", a, b, m, dw, ref_hit(a, b, m, dw));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_signed;
        t_equal;
        t_unsigned;
        t_word;
        t_dword;
        t_any;
        t_strobe;
        t_zero_mask;
        t_random;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule